// File: doc/BRIEF.md
# Three-Level Clamped Inverter Gate Sequencer

This block drives the twelve power switches of a three-phase inverter whose legs each hold four series switches and a clamped midpoint, so that each leg output can sit at the positive rail half, at the midpoint, or at the negative rail half. It runs fundamental-frequency staircase switching. A phase counter steps through one electrical cycle on a clock-enable tick. Each leg is given a positive interval and a negative interval, and each interval is narrowed at both ends by a single programmable delay angle. Choosing that angle places the notches that cancel a chosen low-order harmonic. For example, a fifth of a quarter cycle cancels the fifth harmonic.

Only two commanded pulses are formed per leg: outer-upper (S1) and outer-lower (S4). The inner switches are their complements: S3 is the inverse of S1 and S2 is the inverse of S4. Each complementary pair passes through a dead-band stage. That stage holds both gates low for a programmable number of system clocks whenever the command changes side. The three legs run the same pattern, with legs 1 and 2 lagging leg 0 by one third and two thirds of a cycle. A 2-bit level code per leg shows the commanded level.

Top module: `npc_gate_gen`

## Requirements
- R1: While `rst` is high or `run` is low, all twelve gate outputs are 0 and every leg level code is 2'b10 (off). The phase counter is held at 0.
- R2: With `run` high, the phase counter advances by one only on a clock edge where `tick` is high. After reaching `period`-1 it wraps to 0. Without a tick, the level codes stay frozen.
- R3: For leg 0, with phase p equal to the counter value and latched angle a, the commanded level is +1 (code 2'b01) for a <= p < period/2 - a, and -1 (code 2'b11) for period/2 + a <= p < period - a. It is 0 (code 2'b00) otherwise. The level code appears one clock after the counter holds p.
- R4: Leg k (k = 1, 2) uses phase p = counter - k*(period/3), taken modulo `period`. Its level code sits in bits [2k+1:2k] of `level`.
- R5: The angle input is latched only on the counter wrap to 0, or while `run` is low. A change in the middle of a cycle has no effect until the next wrap.
- R6: An angle of period/4 or more is treated as period/4 - 1.
- R7: With an angle of 0, each leg alternates between +1 and -1 with no 0-level interval.
- R8: S3 is the complement of S1 and S2 is the complement of S4. When a commanded pulse changes, both gates of its pair go low at once. They stay low for max(`dead`,1) clocks, after which the new side turns on.
- R9: A command change that lasts fewer clocks than `dead` never turns on the opposite gate of its pair.
- R10: S1 and S3 are never high together, and S2 and S4 are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Phase counter advance enable |
| run | input | 1 | Inverter enable; low forces all gates off |
| period | input | CNT_W | Counts per electrical cycle (multiple of 12, at least 12) |
| alpha | input | CNT_W | Delay angle in counts |
| dead | input | DT_W | Dead time in system clocks |
| s1 | output | 3 | Outer-upper gate per leg, bit k = leg k |
| s2 | output | 3 | Inner-upper gate per leg (complement of S4) |
| s3 | output | 3 | Inner-lower gate per leg (complement of S1) |
| s4 | output | 3 | Outer-lower gate per leg |
| level | output | 6 | Commanded level code, 2 bits per leg |

## Verification
The phase counter and the latched angle change on the clock edge that samples a tick. The level codes follow one edge later, because the commanded pulses are registered. The gate outputs depend combinationally on the registered pulses, on the dead-band side register, and on `run` and `rst`. A gate therefore drops in the same cycle its pulse changes and rises max(`dead`,1) edges later. The driver applies inputs at the falling edge and advances its own cycle model across the next rising edge. The monitor then compares that predicted state 5 ns after the rising edge, so each result is read in the cycle it is due and before the next inputs are applied.

// File: rtl/npc_pkg.sv
package npc_pkg;
   // Level code reported per leg
   typedef enum logic [1:0] {
      LVL_ZERO = 2'b00,
      LVL_POS  = 2'b01,
      LVL_OFF  = 2'b10,
      LVL_NEG  = 2'b11
   } lvl_e;

   localparam int NUM_LEGS = 3;
endpackage

// File: rtl/npc_angle_ctr.sv
module npc_angle_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] alpha_in,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] alpha_q
);
   generate
      if (CNT_W < 4) begin : g_bad_width
         $error("npc_angle_ctr: CNT_W must be at least 4");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] a_clamped;
   logic             wrap;

   // quarter cycle is the ceiling for the angle
   assign lim       = period >> 2;
   assign a_clamped = (alpha_in >= lim) ? (lim - 1'b1) : alpha_in;
   assign wrap      = (cnt_q >= (period - 1'b1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         alpha_q <= '0;
      end else if (!run) begin
         cnt_q   <= '0;
         alpha_q <= a_clamped;
      end else if (tick) begin
         if (wrap) begin
            cnt_q   <= '0;
            alpha_q <= a_clamped;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt = cnt_q;

   // counter frozen without a tick
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
      (run && !tick) |=> (cnt_q == $past(cnt_q)));

   // angle only reloads at the wrap
   assert_alpha_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (run && !(tick && wrap)) |=> (alpha_q == $past(alpha_q)));
endmodule

// File: rtl/npc_leg_pattern.sv
module npc_leg_pattern #(
   parameter int CNT_W = 12,
   parameter int LEG   = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] alpha,
   input  logic [CNT_W-1:0] period,
   output logic             p_pos,
   output logic             p_neg
);
   generate
      if (LEG < 0 || LEG > 2) begin : g_bad_leg
         $error("npc_leg_pattern: LEG must be 0, 1 or 2");
      end
   endgenerate

   logic [CNT_W-1:0] third;
   logic [CNT_W-1:0] off;
   logic [CNT_W-1:0] half;
   logic [CNT_W:0]   c_w, p_w, o_w, ph_w;
   logic [CNT_W-1:0] phase;
   logic             raw_pos, raw_neg;

   assign third = period / 3;

   // leg offset picked at elaboration
   generate
      if (LEG == 0) begin : g_off0
         assign off = '0;
      end else if (LEG == 1) begin : g_off1
         assign off = third;
      end else begin : g_off2
         assign off = third << 1;
      end
   endgenerate

   assign c_w   = {1'b0, cnt};
   assign p_w   = {1'b0, period};
   assign o_w   = {1'b0, off};
   assign ph_w  = (c_w >= o_w) ? (c_w - o_w) : (c_w + p_w - o_w);
   assign phase = ph_w[CNT_W-1:0];
   assign half  = period >> 1;

   assign raw_pos = (phase >= alpha) && (phase < (half - alpha));
   assign raw_neg = (phase >= (half + alpha)) && (phase < (period - alpha));

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         p_pos <= 1'b0;
         p_neg <= 1'b0;
      end else begin
         p_pos <= raw_pos;
         p_neg <= raw_neg;
      end
   end
endmodule

// File: rtl/npc_dead_band.sv
module npc_dead_band #(
   parameter int DT_W    = 6,
   parameter bit DEAD_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [DT_W-1:0] dead,
   input  logic            pulse,
   output logic            out_hi,
   output logic            out_lo
);
   generate
      if (DT_W < 1) begin : g_bad_dt
         $error("npc_dead_band: DT_W must be at least 1");
      end

      if (DEAD_EN) begin : g_dead
         logic            side_q;
         logic [DT_W-1:0] dc_q;
         logic            match;
         logic [DT_W:0]   dc_next;

         assign match   = (pulse == side_q);
         assign dc_next = {1'b0, dc_q} + 1'b1;

         always_ff @(posedge clk) begin
            if (rst || !en) begin
               side_q <= 1'b0;
               dc_q   <= '0;
            end else if (!match) begin
               if (dc_next >= {1'b0, dead}) begin
                  side_q <= pulse;
                  dc_q   <= '0;
               end else begin
                  dc_q   <= dc_next[DT_W-1:0];
               end
            end else begin
               dc_q <= '0;
            end
         end

         assign out_hi = en &  side_q & match;
         assign out_lo = en & ~side_q & match;

         assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
            !(out_hi && out_lo));

         assert_gates_off_R1: assert property (@(posedge clk) disable iff (rst)
            !en |-> (!out_hi && !out_lo));

         assert_gap_before_hi_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(out_hi) |-> !$past(out_lo));

         assert_gap_before_lo_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(out_lo) |-> !$past(out_hi));
      end else begin : g_plain
         logic unused_in;
         assign unused_in = ^{dead, clk, rst};
         assign out_hi = en &  pulse;
         assign out_lo = en & ~pulse;
      end
   endgenerate
endmodule

// File: rtl/npc_gate_gen.sv
module npc_gate_gen #(
   parameter int CNT_W   = 12,
   parameter int DT_W    = 6,
   parameter bit DEAD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] alpha,
   input  logic [DT_W-1:0]  dead,
   output logic [2:0]       s1,
   output logic [2:0]       s2,
   output logic [2:0]       s3,
   output logic [2:0]       s4,
   output logic [5:0]       level
);
   import npc_pkg::*;

   localparam int LEGS = NUM_LEGS;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] alpha_q;
   logic             en;

   assign en = run & ~rst;

   npc_angle_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .tick     (tick),
      .period   (period),
      .alpha_in (alpha),
      .cnt      (cnt),
      .alpha_q  (alpha_q)
   );

   generate
      for (genvar k = 0; k < LEGS; k++) begin : g_leg
         logic p_pos, p_neg;
         lvl_e lvl;

         npc_leg_pattern #(.CNT_W(CNT_W), .LEG(k)) u_pat (
            .clk    (clk),
            .rst    (rst),
            .run    (run),
            .cnt    (cnt),
            .alpha  (alpha_q),
            .period (period),
            .p_pos  (p_pos),
            .p_neg  (p_neg)
         );

         // upper pulse pair: S1 on the pulse, S3 on its inverse
         npc_dead_band #(.DT_W(DT_W), .DEAD_EN(DEAD_EN)) u_db_top (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .dead   (dead),
            .pulse  (p_pos),
            .out_hi (s1[k]),
            .out_lo (s3[k])
         );

         // lower pulse pair: S4 on the pulse, S2 on its inverse
         npc_dead_band #(.DT_W(DT_W), .DEAD_EN(DEAD_EN)) u_db_bot (
            .clk    (clk),
            .rst    (rst),
            .en     (en),
            .dead   (dead),
            .pulse  (p_neg),
            .out_hi (s4[k]),
            .out_lo (s2[k])
         );

         always_comb begin
            if (!en)        lvl = LVL_OFF;
            else if (p_pos) lvl = LVL_POS;
            else if (p_neg) lvl = LVL_NEG;
            else            lvl = LVL_ZERO;
         end

         assign level[2*k+1:2*k] = lvl;
      end
   endgenerate
endmodule

// File: tb/test_npc_gate_gen.sv
module test_npc_gate_gen;
   localparam int CNT_W = 12;
   localparam int DT_W  = 6;
   localparam int PER   = 120;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             tick = 1'b0;
   logic             run = 1'b0;
   logic [CNT_W-1:0] period = CNT_W'(PER);
   logic [CNT_W-1:0] alpha = '0;
   logic [DT_W-1:0]  dead = '0;
   logic [2:0]       s1, s2, s3, s4;
   logic [5:0]       level;

   always #10 clk = ~clk;

   npc_gate_gen #(.CNT_W(CNT_W), .DT_W(DT_W)) i_npc_gate_gen (
      .clk(clk), .rst(rst), .tick(tick), .run(run), .period(period),
      .alpha(alpha), .dead(dead), .s1(s1), .s2(s2), .s3(s3), .s4(s4),
      .level(level)
   );

   typedef struct {
      logic [5:0] lvl;
      logic [2:0] g1, g2, g3, g4;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   int   r9_hits  = 0;
   bit   done     = 1'b0;

   // cycle model state
   int m_cnt = 0, m_a = 0;
   bit m_p1[3], m_p4[3], m_sd1[3], m_sd4[3];
   int m_dc1[3], m_dc4[3];

   function automatic void db_step(input bit p, inout bit sd, inout int dc, input int dt);
      if (p != sd) begin
         if (dc + 1 >= dt) begin sd = p; dc = 0; end
         else dc = dc + 1;
      end else dc = 0;
   endfunction

   task automatic step(input bit r, input bit rn, input bit tk, input int al,
                       input int dt, input string tag);
      int   old_cnt, old_a, lim, acl, off, ph, half;
      exp_t e;
      @(negedge clk);
      rst = r; run = rn; tick = tk; alpha = CNT_W'(al); dead = DT_W'(dt);
      old_cnt = m_cnt; old_a = m_a;
      lim = PER / 4;
      acl = (al >= lim) ? lim - 1 : al;
      // R2/R5/R6: counter and angle latch
      if (r) begin m_cnt = 0; m_a = 0; end
      else if (!rn) begin m_cnt = 0; m_a = acl; end
      else if (tk) begin
         if (m_cnt >= PER - 1) begin m_cnt = 0; m_a = acl; end
         else m_cnt = m_cnt + 1;
      end
      // R8: dead band uses the previous pulses
      for (int k = 0; k < 3; k++) begin
         if (r || !rn) begin
            m_sd1[k] = 0; m_sd4[k] = 0; m_dc1[k] = 0; m_dc4[k] = 0;
         end else begin
            db_step(m_p1[k], m_sd1[k], m_dc1[k], dt);
            db_step(m_p4[k], m_sd4[k], m_dc4[k], dt);
         end
      end
      // R3/R4: pulses from the previous counter
      half = PER / 2;
      for (int k = 0; k < 3; k++) begin
         off = k * (PER / 3);
         ph  = (old_cnt >= off) ? old_cnt - off : old_cnt + PER - off;
         if (r || !rn) begin m_p1[k] = 0; m_p4[k] = 0; end
         else begin
            m_p1[k] = (ph >= old_a) && (ph < half - old_a);
            m_p4[k] = (ph >= half + old_a) && (ph < PER - old_a);
         end
      end
      e.tag = tag;
      for (int k = 0; k < 3; k++) begin
         bit en;
         en = rn && !r;
         if (!en)          e.lvl[2*k +: 2] = 2'b10;
         else if (m_p1[k]) e.lvl[2*k +: 2] = 2'b01;
         else if (m_p4[k]) e.lvl[2*k +: 2] = 2'b11;
         else              e.lvl[2*k +: 2] = 2'b00;
         e.g1[k] = en &&  m_sd1[k] && (m_p1[k] == m_sd1[k]);
         e.g3[k] = en && !m_sd1[k] && (m_p1[k] == m_sd1[k]);
         e.g4[k] = en &&  m_sd4[k] && (m_p4[k] == m_sd4[k]);
         e.g2[k] = en && !m_sd4[k] && (m_p4[k] == m_sd4[k]);
      end
      exp_q.push_back(e);
   endtask

   // monitor: compare 5 ns after each rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_checks++;
            if (level !== e.lvl) begin
               n_fail++;
               $display("FAIL %s R3/R4 level: got %b expected %b", e.tag, level, e.lvl);
            end
            n_checks++;
            if ({s1, s2, s3, s4} !== {e.g1, e.g2, e.g3, e.g4}) begin
               n_fail++;
               $display("FAIL %s R8 gates s1..s4: got %b %b %b %b expected %b %b %b %b",
                        e.tag, s1, s2, s3, s4, e.g1, e.g2, e.g3, e.g4);
            end
            n_checks++;
            if (((s1 & s3) | (s2 & s4)) != 3'b000) begin
               n_fail++;
               $display("FAIL R10 overlap: got s1&s3=%b s2&s4=%b expected 000",
                        s1 & s3, s2 & s4);
            end
            if (e.tag == "R9" && s1[0]) r9_hits++;
         end
      end
   end

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // watchdog
   initial begin
      #(20 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: got hang expected completion");
      finish_run();
   end

   initial begin
      // R1: reset and idle
      repeat (4) step(1, 0, 0, 0, 0, "R1");
      repeat (3) step(0, 0, 1, 10, 3, "R1");
      // R3, R4, R8: alpha 30 deg
      repeat (250) step(0, 1, 1, 10, 3, "R3");
      // R5: angle changed mid-cycle
      repeat (200) step(0, 1, 1, 20, 3, "R5");
      // R2: sparse ticks
      for (int i = 0; i < 400; i++) step(0, 1, (i % 3) == 0, 20, 3, "R2");
      // R6: clamp above a quarter cycle
      repeat (250) step(0, 1, 1, 50, 2, "R6");
      // R9: two-count pulse under a dead time of six
      repeat (250) step(0, 1, 1, 50, 6, "R9");
      // R7: zero angle
      repeat (250) step(0, 1, 1, 0, 2, "R7");
      // R1: run dropped, then reset
      repeat (10) step(0, 0, 1, 6, 2, "R1");
      repeat (3) step(1, 1, 1, 6, 2, "R1");
      @(posedge clk);
      #6;
      n_checks++;
      if (r9_hits != 0) begin
         n_fail++;
         $display("FAIL R9 short pulse reached S1: got %0d cycles expected 0", r9_hits);
      end
      finish_run();
   end
endmodule